// File: doc/BRIEF.md
# Defective Pixel Replacement Stage

This stage sits in a raster pixel pipeline and patches pixels that are known to be bad. Each pixel arrives with its line number and its position within the line. A list of bad coordinates, sorted in raster order, lives in an external memory. The stage reads that list one entry at a time through a request/response port and keeps exactly one entry ready ahead of the stream. When the pixel in flight has the same coordinate as the ready entry, its value is replaced by an interpolation of its horizontal neighbours. The stage then asks for the next entry.

If the memory answers too slowly, the stream overtakes the list. The ready entry then names a coordinate that has already gone by. The stage detects this case and raises a sticky error flag. It then stops all replacement until the next frame begins. It never stalls the stream and never tries to catch up within the frame. Software clears the flag with a one-cycle clear pulse. The flag also drops by itself once the frame's last pixel has left the stage.

Configuration is a level enable and the number of valid list entries. Both are held stable while a frame is in flight.

Top module: `fpc_engine`

## Requirements
- R1: Every pixel leaves the stage exactly two clock cycles after it enters. The start-of-frame, start-of-line, end-of-line and end-of-frame markers are delayed by the same two cycles. A pixel that is not replaced leaves unchanged. After reset, out_valid, fetch_req and fpc_err are all 0.
- R2: A replaced pixel in the interior of a line becomes floor((left + right) / 2), where left and right are its neighbours on the same line.
- R3: A replaced pixel that is the first of its line takes the value of its right neighbour. A replaced pixel that is the last of its line takes the value of its left neighbour.
- R4: While cfg_enable is 0, no pixel is replaced and no list entry is requested.
- R5: A frame start (in_valid with in_sof) requests list address 0 on the following cycle when cfg_count is nonzero. Each match then requests the next address, counting upward by one. At most cfg_count entries are requested per frame, and every requested address is below cfg_count.
- R6: At most one list request is outstanding at any time. A new request is never issued before the response to the previous one has arrived.
- R7: If the ready entry's coordinate lies earlier in raster order than the pixel being examined, fpc_err is set. That pixel is not replaced.
- R8: After R7 has fired, no further pixel of the same frame is replaced, even if fpc_err has been cleared in the meantime.
- R9: fpc_err stays at 1 until err_clear is pulsed. After the pulse it reads 0 on the next cycle.
- R10: fpc_err also falls by itself in the cycle after the frame's end-of-frame pixel appears at the output.
- R11: Every new frame restarts the list at address 0 and resumes replacement, whatever happened in the previous frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Replacement enable |
| cfg_count | input | CNT_W | Number of valid list entries |
| err_clear | input | 1 | One-cycle pulse that clears fpc_err |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a line |
| in_eol | input | 1 | Last pixel of a line |
| in_eof | input | 1 | Last pixel of a frame |
| in_line | input | LINE_W | Line number of the input pixel |
| in_pix | input | PIX_W | Position of the input pixel within its line |
| in_data | input | DATA_W | Input pixel value |
| fetch_req | output | 1 | List read request, one cycle long |
| fetch_addr | output | CNT_W | List address being requested |
| fetch_valid | input | 1 | List read response valid |
| fetch_line | input | LINE_W | Line coordinate of the returned entry |
| fetch_pix | input | PIX_W | In-line coordinate of the returned entry |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Delayed frame-start marker |
| out_sol | output | 1 | Delayed line-start marker |
| out_eol | output | 1 | Delayed line-end marker |
| out_eof | output | 1 | Delayed frame-end marker |
| out_data | output | DATA_W | Output pixel value |
| fpc_err | output | 1 | Sticky error flag: the list fell behind the stream |

## Verification
The assertions rely on several properties of the inputs:
- in_valid is low during reset.
- Each request receives exactly one response.
- cfg_count and cfg_enable change only between frames.
- The pixels of a line arrive on consecutive cycles, so the live input is the right neighbour.

The stimulus respects all of these. It drives lines without gaps and leaves idle cycles only between lines and between frames. It uses a memory model that answers each request after a fixed delay. Configuration changes happen only after a frame has drained. Fault lists are spaced so that the list keeps up, except in the frames built to make it fall behind.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

   // Which neighbours are available to interpolate a replaced pixel
   typedef enum logic [1:0] {
      NB_BOTH  = 2'd0,
      NB_LEFT  = 2'd1,
      NB_RIGHT = 2'd2,
      NB_NONE  = 2'd3
   } nb_sel_e;

   function automatic nb_sel_e pick_nb(input logic first, input logic last);
      if (first && last)
         return NB_NONE;
      else if (first)
         return NB_RIGHT;
      else if (last)
         return NB_LEFT;
      return NB_BOTH;
   endfunction

endpackage

// File: rtl/fpc_window.sv
module fpc_window
   import fpc_pkg::*;
#(
   parameter int DATA_W   = 10,
   parameter int LINE_W   = 12,
   parameter int PIX_W    = 12,
   parameter int ROUND_UP = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_sol,
   input  logic              in_eol,
   input  logic              in_eof,
   input  logic [LINE_W-1:0] in_line,
   input  logic [PIX_W-1:0]  in_pix,
   input  logic [DATA_W-1:0] in_data,
   input  logic              fix,
   output logic              s1_valid,
   output logic              s1_eof,
   output logic [LINE_W-1:0] s1_line,
   output logic [PIX_W-1:0]  s1_pix,
   output logic              out_valid,
   output logic              out_sof,
   output logic              out_sol,
   output logic              out_eol,
   output logic              out_eof,
   output logic [DATA_W-1:0] out_data
);

   localparam int SUM_W = DATA_W + 1;

   logic              s1_sof, s1_sol, s1_eol;
   logic [DATA_W-1:0] s1_data;
   logic [DATA_W-1:0] left_q;
   logic [SUM_W-1:0]  pair_sum;
   logic [DATA_W-1:0] mean;
   logic [DATA_W-1:0] repl;
   nb_sel_e           nb;

   // Stage 1: the pixel under test; left_q keeps the previous pixel
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_sof   <= 1'b0;
         s1_sol   <= 1'b0;
         s1_eol   <= 1'b0;
         s1_eof   <= 1'b0;
         s1_line  <= '0;
         s1_pix   <= '0;
         s1_data  <= '0;
         left_q   <= '0;
      end else begin
         s1_valid <= in_valid;
         s1_sof   <= in_valid & in_sof;
         s1_sol   <= in_valid & in_sol;
         s1_eol   <= in_valid & in_eol;
         s1_eof   <= in_valid & in_eof;
         s1_line  <= in_line;
         s1_pix   <= in_pix;
         s1_data  <= in_data;
         left_q   <= s1_data;
      end
   end

   // Right neighbour is the live input: lines arrive without gaps
   assign pair_sum = {1'b0, left_q} + {1'b0, in_data};

   generate
      if (ROUND_UP != 0) begin : g_round
         logic [SUM_W-1:0] biased;
         assign biased = pair_sum + 1'b1;
         assign mean   = biased[SUM_W-1:1];
      end else begin : g_trunc
         assign mean = pair_sum[SUM_W-1:1];
      end
   endgenerate

   assign nb = pick_nb(s1_sol, s1_eol);

   always_comb begin
      unique case (nb)
         NB_BOTH:  repl = mean;
         NB_LEFT:  repl = left_q;
         NB_RIGHT: repl = in_data;
         default:  repl = s1_data;
      endcase
   end

   // Stage 2: output register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_sol   <= 1'b0;
         out_eol   <= 1'b0;
         out_eof   <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= s1_valid;
         out_sof   <= s1_sof;
         out_sol   <= s1_sol;
         out_eol   <= s1_eol;
         out_eof   <= s1_eof;
         out_data  <= fix ? repl : s1_data;
      end
   end

endmodule

// File: rtl/fpc_fetch.sv
module fpc_fetch #(
   parameter int LINE_W = 12,
   parameter int PIX_W  = 12,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [CNT_W-1:0]  count,
   input  logic              frame_start,
   input  logic              consume,
   input  logic              fetch_valid,
   input  logic [LINE_W-1:0] fetch_line,
   input  logic [PIX_W-1:0]  fetch_pix,
   output logic              fetch_req,
   output logic [CNT_W-1:0]  fetch_addr,
   output logic              ent_valid,
   output logic [LINE_W-1:0] ent_line,
   output logic [PIX_W-1:0]  ent_pix
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] ptr;      // next list address to request
   logic             pending;  // one request in flight
   logic             drop;     // in-flight answer belongs to an old frame
   logic             have_any;

   assign have_any = enable && (count != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr        <= '0;
         pending    <= 1'b0;
         drop       <= 1'b0;
         fetch_req  <= 1'b0;
         fetch_addr <= '0;
         ent_valid  <= 1'b0;
         ent_line   <= '0;
         ent_pix    <= '0;
      end else begin
         fetch_req <= 1'b0;
         if (frame_start) begin
            ent_valid <= 1'b0;
            ptr       <= '0;
            if (pending && !fetch_valid) begin
               drop <= 1'b1;
            end else begin
               drop    <= 1'b0;
               pending <= 1'b0;
               if (have_any) begin
                  fetch_req  <= 1'b1;
                  fetch_addr <= '0;
                  ptr        <= ONE;
                  pending    <= 1'b1;
               end
            end
         end else if (fetch_valid && pending) begin
            pending <= 1'b0;
            if (drop) begin
               drop <= 1'b0;
               if (have_any) begin
                  fetch_req  <= 1'b1;
                  fetch_addr <= '0;
                  ptr        <= ONE;
                  pending    <= 1'b1;
               end
            end else begin
               ent_valid <= 1'b1;
               ent_line  <= fetch_line;
               ent_pix   <= fetch_pix;
            end
         end else if (consume) begin
            ent_valid <= 1'b0;
            if (enable && (ptr < count)) begin
               fetch_req  <= 1'b1;
               fetch_addr <= ptr;
               ptr        <= ptr + ONE;
               pending    <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/fpc_match.sv
module fpc_match #(
   parameter int LINE_W = 12,
   parameter int PIX_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              err_clear,
   input  logic              frame_start,
   input  logic              s1_valid,
   input  logic              s1_eof,
   input  logic [LINE_W-1:0] s1_line,
   input  logic [PIX_W-1:0]  s1_pix,
   input  logic              ent_valid,
   input  logic [LINE_W-1:0] ent_line,
   input  logic [PIX_W-1:0]  ent_pix,
   output logic              hit,
   output logic              err_flag
);

   logic halt;      // frame-long lockout after a miss
   logic eof_seen;
   logic active;
   logic same_pos;
   logic behind;
   logic late;

   assign active   = s1_valid && enable && !halt && ent_valid;
   assign same_pos = (ent_line == s1_line) && (ent_pix == s1_pix);
   assign behind   = (ent_line < s1_line) ||
                     ((ent_line == s1_line) && (ent_pix < s1_pix));
   assign hit      = active && same_pos;
   assign late     = active && behind;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt     <= 1'b0;
         eof_seen <= 1'b0;
         err_flag <= 1'b0;
      end else begin
         eof_seen <= s1_valid && s1_eof;
         if (frame_start)
            halt <= 1'b0;
         else if (late)
            halt <= 1'b1;
         if (late)
            err_flag <= 1'b1;
         else if (err_clear || eof_seen)
            err_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/fpc_engine.sv
module fpc_engine #(
   parameter int DATA_W   = 10,
   parameter int LINE_W   = 12,
   parameter int PIX_W    = 12,
   parameter int CNT_W    = 8,
   parameter int ROUND_UP = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic              err_clear,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_sol,
   input  logic              in_eol,
   input  logic              in_eof,
   input  logic [LINE_W-1:0] in_line,
   input  logic [PIX_W-1:0]  in_pix,
   input  logic [DATA_W-1:0] in_data,
   output logic              fetch_req,
   output logic [CNT_W-1:0]  fetch_addr,
   input  logic              fetch_valid,
   input  logic [LINE_W-1:0] fetch_line,
   input  logic [PIX_W-1:0]  fetch_pix,
   output logic              out_valid,
   output logic              out_sof,
   output logic              out_sol,
   output logic              out_eol,
   output logic              out_eof,
   output logic [DATA_W-1:0] out_data,
   output logic              fpc_err
);

   initial begin
      assert (DATA_W >= 2) else $fatal(1, "DATA_W must be at least 2");
      assert (LINE_W >= 1 && PIX_W >= 1) else $fatal(1, "coordinate widths must be positive");
      assert (CNT_W >= 1 && CNT_W <= 24) else $fatal(1, "CNT_W out of range");
   end

   logic              frame_start;
   logic              s1_valid, s1_eof;
   logic [LINE_W-1:0] s1_line;
   logic [PIX_W-1:0]  s1_pix;
   logic              ent_valid;
   logic [LINE_W-1:0] ent_line;
   logic [PIX_W-1:0]  ent_pix;
   logic              hit;

   assign frame_start = in_valid && in_sof;

   fpc_window #(
      .DATA_W(DATA_W), .LINE_W(LINE_W), .PIX_W(PIX_W), .ROUND_UP(ROUND_UP)
   ) u_window (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol),
      .in_eol(in_eol), .in_eof(in_eof),
      .in_line(in_line), .in_pix(in_pix), .in_data(in_data),
      .fix(hit),
      .s1_valid(s1_valid), .s1_eof(s1_eof), .s1_line(s1_line), .s1_pix(s1_pix),
      .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
      .out_eol(out_eol), .out_eof(out_eof), .out_data(out_data)
   );

   fpc_fetch #(
      .LINE_W(LINE_W), .PIX_W(PIX_W), .CNT_W(CNT_W)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n),
      .enable(cfg_enable), .count(cfg_count),
      .frame_start(frame_start), .consume(hit),
      .fetch_valid(fetch_valid), .fetch_line(fetch_line), .fetch_pix(fetch_pix),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .ent_valid(ent_valid), .ent_line(ent_line), .ent_pix(ent_pix)
   );

   fpc_match #(
      .LINE_W(LINE_W), .PIX_W(PIX_W)
   ) u_match (
      .clk(clk), .rst_n(rst_n),
      .enable(cfg_enable), .err_clear(err_clear), .frame_start(frame_start),
      .s1_valid(s1_valid), .s1_eof(s1_eof), .s1_line(s1_line), .s1_pix(s1_pix),
      .ent_valid(ent_valid), .ent_line(ent_line), .ent_pix(ent_pix),
      .hit(hit), .err_flag(fpc_err)
   );

endmodule

// File: rtl/fpc_engine_chk.sv
module fpc_engine_chk #(
   parameter int DATA_W = 10,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_enable,
   input logic [CNT_W-1:0]  cfg_count,
   input logic              err_clear,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_data,
   input logic              fetch_req,
   input logic [CNT_W-1:0]  fetch_addr,
   input logic              fetch_valid,
   input logic              out_valid,
   input logic              out_eof,
   input logic [DATA_W-1:0] out_data,
   input logic              fpc_err
);

   logic [1:0] in_flight;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         in_flight <= '0;
      else if (fetch_req && !fetch_valid)
         in_flight <= in_flight + 2'd1;
      else if (!fetch_req && fetch_valid && in_flight != '0)
         in_flight <= in_flight - 2'd1;
   end

   // R1: fixed two-cycle latency of the valid strobe
   a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid, 2));

   // R4: with replacement off the data passes untouched
   a_r4_bypass_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(cfg_enable)) |-> out_data == $past(in_data, 2));

   // R5: requested addresses stay inside the configured list
   a_r5_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> fetch_addr < cfg_count);

   // R6: never a second request while one is outstanding
   a_r6_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> in_flight == '0);

   // R9/R10: the flag only falls after a clear pulse or a frame end
   a_r10_err_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fpc_err) |-> ($past(err_clear) || $past(out_valid && out_eof)));

endmodule

bind fpc_engine fpc_engine_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_fpc_engine.sv
module tb_fpc_engine;

   localparam int DATA_W = 10;
   localparam int LINE_W = 12;
   localparam int PIX_W  = 12;
   localparam int CNT_W  = 8;
   localparam int NL     = 3;
   localparam int NP     = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_enable = 1'b0;
   logic [CNT_W-1:0]  cfg_count = '0;
   logic              err_clear = 1'b0;
   logic              in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0, in_eol = 1'b0, in_eof = 1'b0;
   logic [LINE_W-1:0] in_line = '0;
   logic [PIX_W-1:0]  in_pix = '0;
   logic [DATA_W-1:0] in_data = '0;
   logic              fetch_req;
   logic [CNT_W-1:0]  fetch_addr;
   logic              fetch_valid = 1'b0;
   logic [LINE_W-1:0] fetch_line = '0;
   logic [PIX_W-1:0]  fetch_pix = '0;
   logic              out_valid, out_sof, out_sol, out_eol, out_eof;
   logic [DATA_W-1:0] out_data;
   logic              fpc_err;

   always #2 clk = ~clk;   // 250 MHz

   fpc_engine dut (.*);

   int errors = 0;
   int checks = 0;
   int seed   = 0;
   int req_idx = 0;
   int tbl_line [0:7];
   int tbl_pix  [0:7];
   bit exp_fix  [0:NL-1][0:NP-1];

   logic [DATA_W-1:0] q_data [$];
   logic [3:0]        q_mark [$];
   string             q_tag  [$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int pat(input int l, input int p);
      return (l * 37 + p * 53 + seed * 11 + 5) % 1024;
   endfunction

   // Memory model: answers each request two cycles later
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && fetch_req) begin
            automatic int a = int'(fetch_addr);
            check(a == req_idx, "R5 address order", a, req_idx);
            req_idx++;
            for (int w = 0; w < 2; w++) begin
               @(negedge clk);
               if (w == 1) begin
                  fetch_valid = 1'b1;
                  fetch_line  = LINE_W'(tbl_line[a & 7]);
                  fetch_pix   = PIX_W'(tbl_pix[a & 7]);
               end
               check(!fetch_req, "R6 request while busy", fetch_req, 0);
            end
            @(negedge clk);
            fetch_valid = 1'b0;
         end
      end
   end

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q_data.size() == 0) begin
            check(1'b0, "R1 unexpected output", out_data, -1);
         end else begin
            automatic logic [DATA_W-1:0] ed = q_data.pop_front();
            automatic logic [3:0] em = q_mark.pop_front();
            automatic string t = q_tag.pop_front();
            check(out_data == ed, t, out_data, ed);
            check({out_sof, out_sol, out_eol, out_eof} == em, "R1 markers",
                  {out_sof, out_sol, out_eol, out_eof}, em);
         end
      end
   end

   task automatic set_table(input int a0l, a0p, a1l, a1p, a2l, a2p, a3l, a3p);
      tbl_line[0] = a0l; tbl_pix[0] = a0p;
      tbl_line[1] = a1l; tbl_pix[1] = a1p;
      tbl_line[2] = a2l; tbl_pix[2] = a2p;
      tbl_line[3] = a3l; tbl_pix[3] = a3p;
      for (int i = 4; i < 8; i++) begin tbl_line[i] = 4000; tbl_pix[i] = 0; end
      for (int l = 0; l < NL; l++)
         for (int p = 0; p < NP; p++) exp_fix[l][p] = 1'b0;
   endtask

   // Drives one frame; clr_line: line after which err_clear is pulsed
   // hold_line: line after which fpc_err must still read 1 (R9)
   task automatic send_frame(input string tag, input int clr_line, input int hold_line);
      for (int l = 0; l < NL; l++) begin
         for (int p = 0; p < NP; p++) begin
            automatic int v = pat(l, p);
            @(negedge clk);
            in_valid = 1'b1;
            in_sof = (l == 0 && p == 0);
            in_sol = (p == 0);
            in_eol = (p == NP - 1);
            in_eof = (l == NL - 1 && p == NP - 1);
            in_line = LINE_W'(l);
            in_pix = PIX_W'(p);
            in_data = DATA_W'(v);
            if (exp_fix[l][p]) begin
               if (p == 0) v = pat(l, 1);
               else if (p == NP - 1) v = pat(l, NP - 2);
               else v = (pat(l, p - 1) + pat(l, p + 1)) / 2;
            end
            q_data.push_back(DATA_W'(v));
            q_mark.push_back({in_sof, in_sol, in_eol, in_eof});
            q_tag.push_back(tag);
         end
         if (l != NL - 1) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (l == clr_line) begin
               check(fpc_err == 1'b1, "R7 flag raised", fpc_err, 1);
               err_clear = 1'b1;
               @(negedge clk);
               err_clear = 1'b0;
               check(fpc_err == 1'b0, "R9 clear pulse", fpc_err, 0);
            end else begin
               if (l == hold_line)
                  check(fpc_err == 1'b1, "R9 flag sticky", fpc_err, 1);
               @(negedge clk);
            end
         end
      end
   endtask

   task automatic end_frame(input bit err_at_eof, input int exp_reqs, input string tag);
      automatic bit seen = 1'b0;
      for (int k = 0; k < 8 && !seen; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_sof = 1'b0; in_eof = 1'b0;
         if (out_valid && out_eof) seen = 1'b1;
      end
      check(seen, "R1 end of frame seen", seen, 1);
      check(fpc_err == err_at_eof, "R10 flag at frame end", fpc_err, err_at_eof);
      @(negedge clk);
      check(fpc_err == 1'b0, "R10 flag auto clear", fpc_err, 0);
      repeat (8) @(negedge clk);
      check(q_data.size() == 0, "R1 scoreboard drained", q_data.size(), 0);
      check(req_idx == exp_reqs, tag, req_idx, exp_reqs);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
      check(fetch_req == 1'b0, "R1 reset fetch_req", fetch_req, 0);
      check(fpc_err == 1'b0, "R1 reset flag", fpc_err, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // Frame A: interior (R2) and line-edge (R3) replacement
      seed = 1; req_idx = 0; cfg_enable = 1'b1; cfg_count = 8'd4;
      set_table(0, 5, 1, 0, 1, 9, 2, 4);
      exp_fix[0][5] = 1; exp_fix[1][0] = 1; exp_fix[1][9] = 1; exp_fix[2][4] = 1;
      send_frame("R2 R3 replacement", -1, -1);
      end_frame(1'b0, 4, "R5 request count A");

      // Frame B: disabled (R4)
      seed = 2; req_idx = 0; cfg_enable = 1'b0;
      set_table(0, 5, 1, 0, 1, 9, 2, 4);
      send_frame("R4 disabled passthrough", -1, -1);
      end_frame(1'b0, 0, "R4 no requests");

      // Frame C: count limits the list (R5)
      seed = 3; req_idx = 0; cfg_enable = 1'b1; cfg_count = 8'd2;
      set_table(0, 5, 1, 0, 1, 9, 2, 4);
      exp_fix[0][5] = 1; exp_fix[1][0] = 1;
      send_frame("R5 count limit", -1, -1);
      end_frame(1'b0, 2, "R5 request count C");

      // Frame D: list falls behind, flag cleared mid frame (R7 R8 R9)
      seed = 4; req_idx = 0; cfg_count = 8'd4;
      set_table(0, 3, 0, 4, 1, 2, 2, 5);
      exp_fix[0][3] = 1;
      send_frame("R8 no replacement after miss", 0, -1);
      end_frame(1'b0, 2, "R7 request count D");

      // Frame E: same miss, flag left to clear at frame end (R9 R10)
      seed = 5; req_idx = 0;
      set_table(0, 3, 0, 4, 1, 2, 2, 5);
      exp_fix[0][3] = 1;
      send_frame("R7 miss frame", -1, 1);
      end_frame(1'b1, 2, "R7 request count E");

      // Frame F: recovery on the next frame (R11)
      seed = 6; req_idx = 0;
      set_table(0, 5, 1, 0, 1, 9, 2, 4);
      exp_fix[0][5] = 1; exp_fix[1][0] = 1; exp_fix[1][9] = 1; exp_fix[2][4] = 1;
      send_frame("R11 resume after miss", -1, -1);
      end_frame(1'b0, 4, "R11 request count F");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "R1 watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule